// File: doc/BRIEF.md
# Two-Lane Delay Commutator for a Pipelined Radix-2 FFT

This block sits between two radix-2 butterfly stages of a multi-path pipelined FFT. The previous butterfly delivers two parallel complex streams, an upper lane `u` and a lower lane `v`. In each lane, consecutive blocks of 2·HALF samples belong to one sub-transform. The next butterfly needs each element paired with the element HALF positions later in the same lane. The commutator produces those pairs with a delay line of HALF samples on the lower input and a second delay line of HALF samples on the upper output. Between the two lines sits a two-way crossbar that changes state every HALF accepted samples.

Each output pair appears on the cycle after the input sample that completes it. The pairs drawn from the upper lane come out during the second half of every block. The pairs drawn from the lower lane come out during the first half of the following block. The result is one pair per accepted sample once the delays are full.

The same top module also serves as the front end of the first stage (`FRONT = 1`). In that mode it takes one serial stream on the upper input and buffers the first half of every block. It then emits (x[i], x[i+HALF]) pairs while the second half arrives, so each output lane runs at half the input rate on average. Samples advance only on cycles with `in_valid` high. A `frame_start` flag on an accepted sample makes that sample index 0 of a new frame.

Top module: `dc_commutator`

## Requirements
- R1: Out of reset `out_valid` is low. After reset, or after a restart by `frame_start`, no pair is emitted until the in-frame index of the accepted sample reaches HALF.
- R2: For an accepted sample at in-frame index k, where k mod 2·HALF is in [HALF, 2·HALF), the next cycle shows `top` = u[k−HALF] and `bot` = u[k], with `out_valid` high. Indices are frame-local and count accepted samples only.
- R3: For an accepted sample with k mod 2·HALF in [0, HALF) and k ≥ 2·HALF, the next cycle shows `top` = v[k−2·HALF] and `bot` = v[k−HALF], with `out_valid` high.
- R4: In every emitted pair, the two elements come from the same lane, and the element on `top` is exactly HALF positions earlier than the element on `bot`. Real and imaginary fields pass bit-exact.
- R5: A cycle with `in_valid` low changes neither the in-frame index nor the delay contents, and `out_valid` is low on the next cycle.
- R6: `frame_start` together with `in_valid` makes that sample index 0 and restarts the fill of R1. `frame_start` with `in_valid` low has no effect.
- R7: With `FRONT = 1` the lower inputs have no effect. For k mod 2·HALF ≥ HALF the next cycle shows `top` = u[k−HALF] and `bot` = u[k]. No pair is emitted for the first half of any block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input sample is present this cycle |
| frame_start | input | 1 | The accepted sample is index 0 of a new frame |
| u_re | input | DC_DW | Upper lane (or serial input) real part, signed |
| u_im | input | DC_DW | Upper lane imaginary part, signed |
| v_re | input | DC_DW | Lower lane real part, signed |
| v_im | input | DC_DW | Lower lane imaginary part, signed |
| out_valid | output | 1 | A butterfly input pair is present |
| top_re | output | DC_DW | Earlier element of the pair, real |
| top_im | output | DC_DW | Earlier element of the pair, imaginary |
| bot_re | output | DC_DW | Later element of the pair, real |
| bot_im | output | DC_DW | Later element of the pair, imaginary |

## Verification
The assertions assume that `frame_start` matters only when it coincides with `in_valid`, that reset is applied before the first sample, and that the downstream butterfly never stalls the block. The stimulus follows these assumptions. It also raises `frame_start` alone on idle cycles, to show that such a pulse is ignored. The stimulus mixes stretches of continuous samples, random gaps and a long idle period. It restarts the frame mid-block and on back-to-back samples, so that the crossbar phase has to stay tied to accepted samples rather than to cycles. Two instances, one commutator and one front end, see the same inputs. Every sample carries its frame-local index in the real field, so each pair's index spacing can be read directly.

// File: rtl/dc_pkg.sv
`timescale 1ns/1ps
package dc_pkg;
    parameter int DC_DW = 16;

    typedef struct packed {
        logic signed [DC_DW-1:0] re;
        logic signed [DC_DW-1:0] im;
    } cpx_t;
endpackage

// File: rtl/dc_delay_line.sv
`timescale 1ns/1ps
module dc_delay_line
    import dc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  cpx_t din,
    output cpx_t tail
);
    cpx_t mem_q [DEPTH];
    cpx_t mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (en) begin
            mem_d[0] = din;
            for (int i = 1; i < DEPTH; i++) begin
                mem_d[i] = mem_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    // oldest sample: written DEPTH accepted samples ago
    assign tail = mem_q[DEPTH-1];
endmodule

// File: rtl/dc_phase_ctrl.sv
`timescale 1ns/1ps
module dc_phase_ctrl #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic frame_start,
    output logic second_half,
    output logic filled
);
    localparam int BLK = 2 * HALF;
    localparam int CW  = (BLK > 1) ? $clog2(BLK) : 1;

    typedef struct packed {
        logic [CW-1:0] idx;
        logic          filled;
    } st_t;

    st_t           d, q;
    logic [CW-1:0] eff_idx;
    logic          fill_eff;

    always_comb begin
        eff_idx     = frame_start ? '0 : q.idx;
        fill_eff    = frame_start ? 1'b0 : q.filled;
        second_half = (int'(eff_idx) >= HALF);
        filled      = fill_eff;
        d           = q;
        if (in_valid) begin
            d.idx    = (eff_idx == CW'(BLK - 1)) ? '0 : eff_idx + 1'b1;
            d.filled = fill_eff | second_half;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q.idx) < BLK);

    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(q.idx) && $stable(q.filled)));

    assert_restart_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && frame_start) |=> (q.idx == CW'(1)));
endmodule

// File: rtl/dc_commutator.sv
`timescale 1ns/1ps
module dc_commutator
    import dc_pkg::*;
#(
    parameter int HALF  = 4,
    parameter bit FRONT = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    frame_start,
    input  logic signed [DC_DW-1:0] u_re,
    input  logic signed [DC_DW-1:0] u_im,
    input  logic signed [DC_DW-1:0] v_re,
    input  logic signed [DC_DW-1:0] v_im,
    output logic                    out_valid,
    output logic signed [DC_DW-1:0] top_re,
    output logic signed [DC_DW-1:0] top_im,
    output logic signed [DC_DW-1:0] bot_re,
    output logic signed [DC_DW-1:0] bot_im
);
    typedef struct packed {
        logic valid;
        cpx_t top;
        cpx_t bot;
    } out_t;

    cpx_t u_c, v_c, pair_top, pair_bot;
    logic pair_ok, second_half, filled;
    out_t d, q;

    assign u_c = '{re: u_re, im: u_im};
    assign v_c = '{re: v_re, im: v_im};

    dc_phase_ctrl #(.HALF(HALF)) i_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .frame_start (frame_start),
        .second_half (second_half),
        .filled      (filled)
    );

    if (FRONT) begin : g_front
        cpx_t u_dly;
        dc_delay_line #(.DEPTH(HALF)) i_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (in_valid),
            .din   (u_c),
            .tail  (u_dly)
        );
        assign pair_top = u_dly;
        assign pair_bot = u_c;
        assign pair_ok  = in_valid & second_half;
    end else begin : g_comm
        cpx_t v_dly, t_dly, t_in;
        dc_delay_line #(.DEPTH(HALF)) i_lower (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (in_valid),
            .din   (v_c),
            .tail  (v_dly)
        );
        // crossbar: straight in the first half, crossed in the second
        assign t_in = second_half ? v_dly : u_c;
        dc_delay_line #(.DEPTH(HALF)) i_upper (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (in_valid),
            .din   (t_in),
            .tail  (t_dly)
        );
        assign pair_top = t_dly;
        assign pair_bot = second_half ? u_c : v_dly;
        assign pair_ok  = in_valid & (second_half | filled);
    end

    always_comb begin
        d       = q;
        d.valid = pair_ok;
        if (pair_ok) begin
            d.top = pair_top;
            d.bot = pair_bot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.valid;
    assign top_re    = q.top.re;
    assign top_im    = q.top.im;
    assign bot_re    = q.bot.re;
    assign bot_im    = q.bot.im;

    assert_idle_no_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_first_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && frame_start && (HALF > 1)) |=> !out_valid);
endmodule

// File: tb/test_dc_commutator.sv
`timescale 1ns/1ps
module test_dc_commutator;
    import dc_pkg::*;

    localparam int NA = 4;
    localparam int NB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic in_valid = 1'b0, frame_start = 1'b0;
    logic signed [DC_DW-1:0] u_re = '0, u_im = '0, v_re = '0, v_im = '0;
    logic a_v, b_v;
    logic signed [DC_DW-1:0] a_tr, a_ti, a_br, a_bi, b_tr, b_ti, b_br, b_bi;

    dc_commutator #(.HALF(NA), .FRONT(1'b0)) i_dc_commutator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_start(frame_start),
        .u_re(u_re), .u_im(u_im), .v_re(v_re), .v_im(v_im),
        .out_valid(a_v), .top_re(a_tr), .top_im(a_ti), .bot_re(a_br), .bot_im(a_bi));

    dc_commutator #(.HALF(NB), .FRONT(1'b1)) i_dc_commutator_front (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_start(frame_start),
        .u_re(u_re), .u_im(u_im), .v_re(v_re), .v_im(v_im),
        .out_valid(b_v), .top_re(b_tr), .top_im(b_ti), .bot_re(b_br), .bot_im(b_bi));

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] hu[$];
    logic [31:0] hv[$];
    bit restarted = 0;

    bit          ea_v, eb_v;
    logic [31:0] ea_t, ea_b, eb_t, eb_b;
    string       ea_tag, eb_tag;

    task automatic predict(input int n, input bit front, input bit cur,
                           output bit ev, output logic [31:0] et, output logic [31:0] eb,
                           output string tag);
        int k;
        int r;
        ev = 0; et = '0; eb = '0;
        tag = restarted ? "R6" : "R1";
        if (!cur) begin
            tag = "R5";
            return;
        end
        k = hu.size() - 1;
        r = k % (2 * n);
        if (front) begin
            tag = "R7";
            if (r >= n) begin
                ev = 1; et = hu[k-n]; eb = hu[k];
            end
        end else if (r >= n) begin
            tag = "R2"; ev = 1; et = hu[k-n]; eb = hu[k];
        end else if (k >= 2 * n) begin
            tag = "R3"; ev = 1; et = hv[k-2*n]; eb = hv[k-n];
        end
    endtask

    task automatic compare(input string who, input int n, input bit gv,
                           input logic [31:0] gt, input logic [31:0] gb,
                           input bit ev, input logic [31:0] et, input logic [31:0] eb,
                           input string tag);
        checks++;
        if (gv !== ev) begin
            errors++;
            $display("FAIL %s %s: out_valid=%0b expected %0b", tag, who, gv, ev);
        end else if (ev) begin
            checks++;
            if (gt !== et || gb !== eb) begin
                errors++;
                $display("FAIL %s %s: pair=%h/%h expected %h/%h", tag, who, gt, gb, et, eb);
            end
            // R4: index spacing carried in the real tag
            checks++;
            if (int'($signed(gb[31:16])) - int'($signed(gt[31:16])) != n) begin
                errors++;
                $display("FAIL R4 %s: spacing=%0d expected %0d", who,
                         int'($signed(gb[31:16])) - int'($signed(gt[31:16])), n);
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit v;
        bit fs;
        ea_v = 0; eb_v = 0; ea_t = '0; ea_b = '0; eb_t = '0; eb_b = '0;
        ea_tag = "R5"; eb_tag = "R5";
        repeat (3) begin
            @(negedge clk);
            compare("reset-main", NA, a_v, {a_tr, a_ti}, {a_br, a_bi}, 0, '0, '0, "R1");
            compare("reset-front", NB, b_v, {b_tr, b_ti}, {b_br, b_bi}, 0, '0, '0, "R1");
        end
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            compare("main", NA, a_v, {a_tr, a_ti}, {a_br, a_bi}, ea_v, ea_t, ea_b, ea_tag);
            compare("front", NB, b_v, {b_tr, b_ti}, {b_br, b_bi}, eb_v, eb_t, eb_b, eb_tag);
            if (cyc < 300) v = 1;
            else if (cyc < 1500) v = ($urandom % 4) != 0;
            else if (cyc < 1600) v = 0;
            else v = ($urandom % 2) != 0;
            fs = 0;
            if (cyc == 700 || cyc == 1703 || cyc == 2101 || cyc == 2102 || cyc == 3001) begin
                v = 1; fs = 1;
            end
            if (cyc == 900 || cyc == 2500) begin
                v = 0; fs = 1;   // R6: ignored without in_valid
            end
            in_valid = v;
            frame_start = fs;
            if (v) begin
                int k;
                if (fs) begin
                    hu.delete(); hv.delete(); restarted = 1;
                end
                k = hu.size();
                u_re = DC_DW'(k);
                u_im = DC_DW'(-k - 1);
                v_re = DC_DW'(k + 8000);
                v_im = DC_DW'(3 * k);
                hu.push_back({u_re, u_im});
                hv.push_back({v_re, v_im});
            end else begin
                u_re = DC_DW'(-5); u_im = DC_DW'(77);
                v_re = DC_DW'(-9); v_im = DC_DW'(55);
            end
            predict(NA, 0, v, ea_v, ea_t, ea_b, ea_tag);
            predict(NB, 1, v, eb_v, eb_t, eb_b, eb_tag);
        end
        @(negedge clk);
        compare("main", NA, a_v, {a_tr, a_ti}, {a_br, a_bi}, ea_v, ea_t, ea_b, ea_tag);
        compare("front", NB, b_v, {b_tr, b_ti}, {b_br, b_bi}, eb_v, eb_t, eb_b, eb_tag);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule